// File: doc/BRIEF.md
# Host Bridge Outbound Master with Retry Backoff

This block is the bus-side controller of a bridge that sits between a processor and an expansion bus. It runs processor-initiated cycles onto the bus as a bus master, and as a memory target it accepts write cycles that other masters on the bus aim at system memory. When the addressed target ends a processor cycle with a retry, the block releases its bus request for a fixed backoff window. It then arbitrates again and reissues the same cycle. The processor sees no acknowledge until a cycle ends without retry.

The inbound memory target has no path to the outbound sequencer. A write from another master completes as soon as the memory port is ready, whether or not a processor cycle is outstanding. This keeps the system out of two endless loops. In the first, the bridge holds the bus and keeps repeating a cycle that a downstream bridge retries while it still holds posted write data. In the second, the bridge refuses that downstream bridge's flush writes while it waits for its own cycle. The backoff length and the inbound wait limit are parameters.

Top module: `host_bridge_master`

## Requirements
- R1: While reset is asserted and until the first request, `bus_req`, `cpu_ack`, `mem_wr_en`, `in_wr_done` and `in_wr_retry` are all 0.
- R2: In idle, a high `cpu_req_valid` raises `bus_req` on the following cycle. `cpu_ack` stays 0 until a completion.
- R3: `bus_req` stays high while the block waits for `bus_gnt`, and also during the cycle that follows a grant, which is the cycle in which the termination is reported.
- R4: A termination with `bus_term_retry`=1 drops `bus_req` to 0 for exactly BACKOFF_CYCLES cycles (default 2). The window starts on the cycle after the termination. `bus_req` then goes high again.
- R5: A retried cycle is reissued after every retry, with no limit on the number of retries. No `cpu_ack` is given for a retry.
- R6: A termination with `bus_term_retry`=0 makes `cpu_ack` high for exactly one cycle, the cycle after the termination. In that cycle `bus_req` is 0.
- R7: When `in_wr_valid` and `mem_ready` are both high and no response is showing, `mem_wr_en` is high in that cycle and `in_wr_done` is high for one cycle on the next. This holds in every outbound state, including a pending, retried or backing-off processor cycle.
- R8: An inbound write that has met a low `mem_ready` for WAIT_LIMIT consecutive cycles ends with a one-cycle `in_wr_retry` pulse. `in_wr_done` and `in_wr_retry` are never high together.
- R9: With a downstream bridge that retries processor cycles while it holds posted data, and flushes that data whenever the bus is free, every processor request is acknowledged within a bounded number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request, held until acknowledged |
| cpu_ack | output | 1 | One-cycle completion acknowledge to the processor |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_term_valid | input | 1 | Termination of the mastered cycle is reported |
| bus_term_retry | input | 1 | 1 = retry termination, 0 = normal completion |
| in_wr_valid | input | 1 | Inbound memory write pending from another master |
| mem_ready | input | 1 | Memory port can take the write this cycle |
| mem_wr_en | output | 1 | Write strobe to the memory port |
| in_wr_done | output | 1 | Inbound write completed |
| in_wr_retry | output | 1 | Inbound write terminated with retry |

## Verification
A wrong sequencer state shows on `bus_req` within one cycle of a termination. A bad backoff count shows as a low window that is too short or too long, or as a request that never returns. A lost retry shows as an early `cpu_ack`. Coupling between the inbound target and the outbound side shows as a missing `in_wr_done`, one cycle after a ready write, while a processor cycle is waiting. The downstream-bridge scenario turns either livelock into an acknowledge that never arrives within its cycle bound.

// File: rtl/hbm_pkg.sv
package hbm_pkg;
  typedef enum logic [2:0] {
    M_IDLE    = 3'd0,
    M_REQ     = 3'd1,
    M_ACTIVE  = 3'd2,
    M_BACKOFF = 3'd3,
    M_DONE    = 3'd4
  } mst_state_e;
endpackage

// File: rtl/hbm_reset_sync.sv
module hbm_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/hbm_backoff_timer.sv
module hbm_backoff_timer #(
  parameter int BACKOFF_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = $clog2(BACKOFF_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BACKOFF_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = start | run;

  always_comb begin
    if (start)            cnt_d = '0;
    else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = run & (cnt_q == LAST);
endmodule

// File: rtl/hbm_master_fsm.sv
module hbm_master_fsm
  import hbm_pkg::*;
#(
  parameter int BACKOFF_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req_valid,
  input  logic bus_gnt,
  input  logic bus_term_valid,
  input  logic bus_term_retry,
  output logic bus_req,
  output logic cpu_ack
);
  mst_state_e state_q, state_d;
  logic       bo_start, bo_run, bo_expire;

  assign bo_start = (state_q == M_ACTIVE) & bus_term_valid & bus_term_retry;
  assign bo_run   = (state_q == M_BACKOFF);

  hbm_backoff_timer #(.BACKOFF_CYCLES(BACKOFF_CYCLES)) u_backoff (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (bo_start),
    .run    (bo_run),
    .expire (bo_expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      M_IDLE:    if (cpu_req_valid) state_d = M_REQ;
      M_REQ:     if (bus_gnt) state_d = M_ACTIVE;
      M_ACTIVE:  if (bus_term_valid) state_d = bus_term_retry ? M_BACKOFF : M_DONE;
      M_BACKOFF: if (bo_expire) state_d = M_REQ;
      M_DONE:    state_d = M_IDLE;
      default:   state_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= M_IDLE;
    else        state_q <= state_d;
  end

  assign bus_req = (state_q == M_REQ) | (state_q == M_ACTIVE);
  assign cpu_ack = (state_q == M_DONE);
endmodule

// File: rtl/hbm_inbound_target.sv
module hbm_inbound_target #(
  parameter int WAIT_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_wr_valid,
  input  logic mem_ready,
  output logic mem_wr_en,
  output logic in_wr_done,
  output logic in_wr_retry
);
  localparam int WAIT_W = $clog2(WAIT_LIMIT + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_LIMIT - 1);

  logic              done_q, retry_q;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              pending, accept, give_up;

  assign pending = in_wr_valid & ~done_q & ~retry_q;
  assign accept  = pending & mem_ready;
  assign give_up = pending & ~mem_ready & (wait_q == WAIT_LAST);

  always_comb begin
    if (!pending || mem_ready || give_up) wait_d = '0;
    else                                  wait_d = wait_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      retry_q <= 1'b0;
      wait_q  <= '0;
    end else begin
      done_q  <= accept;
      retry_q <= give_up;
      wait_q  <= wait_d;
    end
  end

  assign mem_wr_en   = accept;
  assign in_wr_done  = done_q;
  assign in_wr_retry = retry_q;
endmodule

// File: rtl/host_bridge_master.sv
module host_bridge_master #(
  parameter int BACKOFF_CYCLES = 2,
  parameter int WAIT_LIMIT     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req_valid,
  output logic cpu_ack,
  output logic bus_req,
  input  logic bus_gnt,
  input  logic bus_term_valid,
  input  logic bus_term_retry,
  input  logic in_wr_valid,
  input  logic mem_ready,
  output logic mem_wr_en,
  output logic in_wr_done,
  output logic in_wr_retry
);
  logic rst_sync_n;

  hbm_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hbm_master_fsm #(.BACKOFF_CYCLES(BACKOFF_CYCLES)) u_master (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .cpu_req_valid  (cpu_req_valid),
    .bus_gnt        (bus_gnt),
    .bus_term_valid (bus_term_valid),
    .bus_term_retry (bus_term_retry),
    .bus_req        (bus_req),
    .cpu_ack        (cpu_ack)
  );

  hbm_inbound_target #(.WAIT_LIMIT(WAIT_LIMIT)) u_inbound (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .in_wr_valid (in_wr_valid),
    .mem_ready   (mem_ready),
    .mem_wr_en   (mem_wr_en),
    .in_wr_done  (in_wr_done),
    .in_wr_retry (in_wr_retry)
  );
endmodule

// File: rtl/hbm_checker.sv
module hbm_checker (
  input logic clk,
  input logic rst_n,
  input logic cpu_ack,
  input logic bus_req,
  input logic bus_term_valid,
  input logic bus_term_retry,
  input logic in_wr_valid,
  input logic mem_ready,
  input logic in_wr_done,
  input logic in_wr_retry
);
  AST_BACKOFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_term_valid && bus_term_retry) |=> (!bus_req ##1 !bus_req)); // R4

  AST_NO_ACK_ON_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_term_valid && bus_term_retry) |=> !cpu_ack); // R5

  AST_ACK_AFTER_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_term_valid && !bus_term_retry) |=> (cpu_ack && !bus_req)); // R6

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack); // R6

  AST_INBOUND_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr_valid && mem_ready && !in_wr_done && !in_wr_retry) |=> in_wr_done); // R7

  AST_INBOUND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_wr_done && in_wr_retry)); // R8

  AST_RETRY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_wr_retry) |-> $past(!mem_ready)); // R8
endmodule

bind host_bridge_master hbm_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_ack        (cpu_ack),
  .bus_req        (bus_req),
  .bus_term_valid (bus_term_valid),
  .bus_term_retry (bus_term_retry),
  .in_wr_valid    (in_wr_valid),
  .mem_ready      (mem_ready),
  .in_wr_done     (in_wr_done),
  .in_wr_retry    (in_wr_retry)
);

// File: tb/host_bridge_master_tb.sv
module host_bridge_master_tb;
  localparam int BO = 2;
  localparam int WL = 4;

  logic clk, rst_n;
  logic cpu_req_valid, cpu_ack, bus_req, bus_gnt, bus_term_valid, bus_term_retry;
  logic in_wr_valid, mem_ready, mem_wr_en, in_wr_done, in_wr_retry;
  int   n_cmp, n_bad;
  bit   finished;

  host_bridge_master #(.BACKOFF_CYCLES(BO), .WAIT_LIMIT(WL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid), .cpu_ack(cpu_ack),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_term_valid(bus_term_valid),
    .bus_term_retry(bus_term_retry), .in_wr_valid(in_wr_valid), .mem_ready(mem_ready),
    .mem_wr_en(mem_wr_en), .in_wr_done(in_wr_done), .in_wr_retry(in_wr_retry)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // expected inbound response for one cycle of the bench model
  function automatic int exp_inbound(input bit rdy, input int waits);
    if (rdy) return 1;
    if (waits == WL - 1) return 2;
    return 0;
  endfunction

  task automatic inbound_now(input string req);
    in_wr_valid = 1'b1; mem_ready = 1'b1;
    #1 chk(req, "mem_wr_en", mem_wr_en, 1);
    tick();
    chk(req, "in_wr_done", in_wr_done, 1);
    chk(req, "in_wr_retry", in_wr_retry, 0);
    in_wr_valid = 1'b0; mem_ready = 1'b0;
  endtask

  // directed/random processor transaction with n_retry retries
  task automatic cpu_txn(input int n_retry, input int gnt_delay, input bit with_inbound);
    cpu_req_valid = 1'b1;
    tick();
    chk("R2", "bus_req after request", bus_req, 1);
    chk("R2", "cpu_ack before completion", cpu_ack, 0);
    if (with_inbound) inbound_now("R7 pending-request");
    for (int a = 0; a <= n_retry; a++) begin
      for (int i = 0; i < gnt_delay; i++) begin
        tick();
        chk("R3", "bus_req while ungranted", bus_req, 1);
      end
      bus_gnt = 1'b1;
      tick();
      chk("R3", "bus_req in granted cycle", bus_req, 1);
      bus_gnt = 1'b0;
      bus_term_valid = 1'b1;
      bus_term_retry = (a < n_retry);
      tick();
      bus_term_valid = 1'b0;
      bus_term_retry = 1'b0;
      if (a < n_retry) begin
        chk("R4", "bus_req backoff cycle 1", bus_req, 0);
        chk("R5", "no cpu_ack on retry", cpu_ack, 0);
        if (with_inbound && a == 0) inbound_now("R7 during-backoff");
        else begin
          tick();
        end
        chk("R4", "bus_req backoff cycle 2", bus_req, 0);
        tick();
        chk("R4", "bus_req reasserted", bus_req, 1);
        chk("R5", "still no cpu_ack", cpu_ack, 0);
      end else begin
        chk("R6", "cpu_ack after completion", cpu_ack, 1);
        chk("R6", "bus_req released", bus_req, 0);
        cpu_req_valid = 1'b0;
        tick();
        chk("R6", "cpu_ack pulse width", cpu_ack, 0);
        chk("R6", "bus_req idle", bus_req, 0);
      end
    end
  endtask

  // downstream bridge holding posted data and retrying processor cycles
  task automatic deadlock_scenario(input int limit);
    bit posted = 1'b1, granted_last = 1'b0, bridge_busy = 1'b0;
    bit acked = 1'b0, flushed_while_pending = 1'b0;
    cpu_req_valid = 1'b1;
    tick();
    for (int c = 0; c < limit && !acked; c++) begin
      bus_term_valid = granted_last;
      bus_term_retry = granted_last && posted;
      if (cpu_ack) acked = 1'b1;
      if (in_wr_done) begin
        posted = 1'b0; bridge_busy = 1'b0;
        in_wr_valid = 1'b0; mem_ready = 1'b0;
        if (!acked) flushed_while_pending = 1'b1;
      end
      bus_gnt = bus_req && !granted_last && !bridge_busy && !acked;
      granted_last = bus_gnt;
      if (posted && !bridge_busy && !bus_req) begin
        bridge_busy = 1'b1; in_wr_valid = 1'b1; mem_ready = 1'b1;
      end
      if (!acked) tick();
    end
    chk("R9", "processor request acknowledged", acked, 1);
    chk("R9", "posted flush accepted while pending", flushed_while_pending, 1);
    cpu_req_valid = 1'b0; bus_gnt = 1'b0; bus_term_valid = 1'b0; bus_term_retry = 1'b0;
    in_wr_valid = 1'b0; mem_ready = 1'b0;
    tick(); tick();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL R9 watchdog actual=hang expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int waits, got;
    bit rdy;
    void'($urandom(32'h5eed_0042));
    n_cmp = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0;
    cpu_req_valid = 0; bus_gnt = 0; bus_term_valid = 0; bus_term_retry = 0;
    in_wr_valid = 0; mem_ready = 0;
    tick(); tick();
    chk("R1", "bus_req in reset", bus_req, 0);
    chk("R1", "cpu_ack in reset", cpu_ack, 0);
    chk("R1", "in_wr_done in reset", in_wr_done, 0);
    chk("R1", "in_wr_retry in reset", in_wr_retry, 0);
    chk("R1", "mem_wr_en in reset", mem_wr_en, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1", "bus_req after reset", bus_req, 0);

    // directed corners
    cpu_txn(0, 0, 1'b0);
    cpu_txn(1, 0, 1'b1);
    cpu_txn(5, 2, 1'b0);

    // random processor transactions
    for (int n = 0; n < 40; n++) begin
      cpu_txn(int'($urandom_range(0, 4)), int'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0));
    end

    // random inbound writes against the bench model
    for (int n = 0; n < 40; n++) begin
      waits = 0;
      in_wr_valid = 1'b1;
      for (int c = 0; c < 2 * WL; c++) begin
        rdy = ($urandom_range(0, 2) == 0);
        mem_ready = rdy;
        tick();
        got = exp_inbound(rdy, waits);
        chk(got == 2 ? "R8" : "R7", "in_wr_done", in_wr_done, got == 1);
        chk(got == 2 ? "R8" : "R7", "in_wr_retry", in_wr_retry, got == 2);
        if (got != 0) break;
        waits++;
      end
      in_wr_valid = 1'b0; mem_ready = 1'b0;
      tick();
      chk("R8", "response is a pulse", in_wr_done | in_wr_retry, 0);
    end

    // directed: never ready for exactly WL cycles
    in_wr_valid = 1'b1; mem_ready = 1'b0;
    for (int c = 0; c < WL - 1; c++) begin
      tick();
      chk("R8", "no early retry", in_wr_retry, 0);
    end
    tick();
    chk("R8", "retry at wait limit", in_wr_retry, 1);
    chk("R8", "done not with retry", in_wr_done, 0);
    in_wr_valid = 1'b0;
    tick();

    // downstream-bridge livelock scenarios
    for (int n = 0; n < 6; n++) begin
      repeat ($urandom_range(0, 3)) tick();
      deadlock_scenario(40);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule